// File: doc/BRIEF.md
# Converter Serial Port Interface

This block is the device-side digital serial port of a 10-bit multichannel converter. A host on a shared serial bus writes a control word into it and reads the latest conversion result back. The serial clock, the two frame syncs and the data input come from the host. The block samples them in a faster system clock domain, passes each through a two-flop synchroniser and detects its edges. The conversion itself is outside the block. A parallel result bus with a valid strobe stands in for it.

Writes and reads are framed separately. A falling edge on the write frame sync arms a write. The control word then enters MSB first on falling serial-clock edges. A write needs 13 pulses to complete, but only the first 10 carry data. The word is committed at the 13th pulse, and only when its package bit equals the hardwired address pin. This lets two devices share one bus. A rising edge on the read frame sync copies the held result into a shadow register. The block then drives it out MSB first, changing the bit on rising serial-clock edges. The data-output enable drops at the 11th rising edge.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the control word is zero and the data-output enable is low.
- R2: A write frame starts on a write-sync falling edge. The next 10 falling serial-clock edges shift the control word in MSB first. The word is laid out as bit 9 power-down, bit 8 external-reference select, bit 7 package address, bits 6:4 channel, and bits 3:0 reserved. The word reaches the control outputs after the 13th falling edge.
- R3: After only 12 pulses of a write, the control word still holds its previous value.
- R4: Data-input values during pulses 11 to 13 of a write have no effect on the committed word.
- R5: A new write-sync falling edge in the middle of a write abandons that write and leaves the control word unchanged. The new frame then writes normally.
- R6: A completed write whose package bit (bit 7) differs from the address pin leaves the control word unchanged.
- R7: Serial-clock pulses with no read-sync rising edge leave the data-output enable low.
- R8: A read-sync rising edge enables the output with the result MSB present. Rising serial-clock edges 2 to 10 each present the next lower bit.
- R9: The output enable drops at the 11th rising edge of a read. Later pulses do not re-enable it until a new read-sync rising edge arrives.
- R10: A result strobed in during a read does not change the bits of that read. The next read returns it.
- R11: The output enable rises only while the committed package bit equals the address pin.
- R12: The result-valid strobe captures the parallel result for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| wr_sync_n | input | 1 | Write frame sync; a falling edge arms a write |
| rd_sync | input | 1 | Read frame sync; a rising edge starts a read |
| sdi | input | 1 | Serial data in |
| pkg_addr | input | 1 | Hardwired package address pin |
| res_data | input | 10 | Conversion result |
| res_valid | input | 1 | Strobe that captures res_data |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Tri-state enable for sdo |
| ctrl_word | output | 10 | Committed control word |
| pwr_down | output | 1 | Power-down field |
| ext_ref | output | 1 | External-reference select field |
| chan_sel | output | 3 | Channel select field |

## Verification
The bench builds the block with its default parameters: a 10-bit word, 13 write pulses and two synchroniser stages. The serial clock runs at 8 system clocks per half period. With the 10-bit word, a single frame reaches both the 10-versus-13 pulse boundary of a write and the 11th-pulse release of a read. Toggling the address pin at run time brings both sides of the package match into reach.

// File: rtl/adcsp_pkg.sv
// Shared sizes and control-word field positions for the serial port.
package adcsp_pkg;
    localparam int WORD_W   = 10;
    localparam int PD_BIT   = 9;
    localparam int EXT_BIT  = 8;
    localparam int PKG_BIT  = 7;
    localparam int CH_HI    = 6;
    localparam int CH_LO    = 4;
endpackage

// File: rtl/adcsp_edge.sv
// Two-or-more-flop synchroniser with rise/fall detect for one async input.
// Assumes the input is stable for at least STAGES+1 system clocks per level.
module adcsp_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;
    logic              lvl;

    // Shift the input through the synchroniser and keep last synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            prev  <= chain[STAGES-1];
        end
    end

    // Edge pulses from synced level against its previous value.
    always_comb begin
        lvl  = chain[STAGES-1];
        rise = lvl & ~prev;
        fall = ~lvl & prev;
    end
endmodule

// File: rtl/adcsp_wr.sv
// Write path: after an arming edge, shifts DATA_W bits MSB first on serial
// clock falls, waits for PULSES falls total, then commits if the package bit
// matches the address pin. A new arming edge restarts the frame.
module adcsp_wr #(
    parameter int DATA_W  = 10,
    parameter int PULSES  = 13,
    parameter int PKG_POS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              bit_fall,
    input  logic              bit_in,
    input  logic              pkg_addr,
    output logic [DATA_W-1:0] ctrl_q
);
    localparam int CW = $clog2(PULSES + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSES - 1);
    localparam logic [CW-1:0] NDAT = CW'(DATA_W);

    logic              armed;
    logic [CW-1:0]     cnt;
    logic [DATA_W-1:0] sh;

    // Frame counter, shifter and commit of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            cnt    <= '0;
            sh     <= '0;
            ctrl_q <= '0;
        end else if (arm) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (armed && bit_fall) begin
            if (cnt < NDAT) sh <= {sh[DATA_W-2:0], bit_in};
            if (cnt == LAST) begin
                armed <= 1'b0;
                cnt   <= '0;
                if (sh[PKG_POS] == pkg_addr) ctrl_q <= sh;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R2: counter never runs past the last pulse of a frame.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R3: the control word only changes right after the final pulse.
    a_r3_commit_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_q) |-> ($past(cnt) == LAST && $past(armed) && $past(bit_fall)));
endmodule

// File: rtl/adcsp_rd.sv
// Read path: holds the latest result; a frame-start edge copies it to a
// shadow and presents the MSB; rising clock edges 2..DATA_W shift lower bits
// out; edge DATA_W+1 ends the frame and clears the counter.
module adcsp_rd #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              bit_rise,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_valid,
    output logic              dout,
    output logic              active
);
    localparam int CW = $clog2(DATA_W + 1);
    localparam logic [CW-1:0] ENDC = CW'(DATA_W);

    logic [DATA_W-1:0] result_q;
    logic [DATA_W-1:0] sh;
    logic [CW-1:0]     cnt;

    // Hold the most recent conversion result.
    always_ff @(posedge clk) begin
        if (!rst_n)         result_q <= '0;
        else if (res_valid) result_q <= res_data;
    end

    // Shadow load, bit counter and output shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (start) begin
            sh     <= result_q;
            cnt    <= '0;
            active <= 1'b1;
        end else if (active && bit_rise) begin
            if (cnt == ENDC) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
                if (cnt != '0) sh <= {sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign dout = sh[DATA_W-1];

    // R9: the read counter stops at the release pulse.
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= ENDC);

    // R8: output bit holds between rising clock edges inside a frame.
    a_r8_dout_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && !$past(bit_rise) && !$past(start)) |-> $stable(dout));
endmodule

// File: rtl/adc_serial_port.sv
// Top of the converter serial port: synchronises the host signals, runs the
// independent write and read paths and gates the output enable by package
// address match. Assumes every host signal is slow against clk.
module adc_serial_port
    import adcsp_pkg::*;
#(
    parameter int DATA_W   = WORD_W,
    parameter int WR_PULSE = 13,
    parameter int STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              wr_sync_n,
    input  logic              rd_sync,
    input  logic              sdi,
    input  logic              pkg_addr,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_valid,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              pwr_down,
    output logic              ext_ref,
    output logic [2:0]        chan_sel
);
    logic sclk_rise, sclk_fall, wr_rise, wr_fall, rd_rise, rd_fall;
    logic [STAGES-1:0] sdi_chain;
    logic rd_active;

    adcsp_edge #(.STAGES(STAGES)) u_sclk (.clk(clk), .rst_n(rst_n), .d(sclk),
        .rise(sclk_rise), .fall(sclk_fall));
    adcsp_edge #(.STAGES(STAGES)) u_wsync (.clk(clk), .rst_n(rst_n), .d(wr_sync_n),
        .rise(wr_rise), .fall(wr_fall));
    adcsp_edge #(.STAGES(STAGES)) u_rsync (.clk(clk), .rst_n(rst_n), .d(rd_sync),
        .rise(rd_rise), .fall(rd_fall));

    // Synchronise serial data with the same latency as the clock edges.
    always_ff @(posedge clk) begin
        if (!rst_n) sdi_chain <= '0;
        else        sdi_chain <= {sdi_chain[STAGES-2:0], sdi};
    end

    adcsp_wr #(.DATA_W(DATA_W), .PULSES(WR_PULSE), .PKG_POS(PKG_BIT)) u_wr (
        .clk(clk), .rst_n(rst_n), .arm(wr_fall), .bit_fall(sclk_fall),
        .bit_in(sdi_chain[STAGES-1]), .pkg_addr(pkg_addr), .ctrl_q(ctrl_word));

    adcsp_rd #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .start(rd_rise), .bit_rise(sclk_rise),
        .res_data(res_data), .res_valid(res_valid), .dout(sdo), .active(rd_active));

    // Decode fields and gate the output by package match.
    always_comb begin
        pwr_down = ctrl_word[PD_BIT];
        ext_ref  = ctrl_word[EXT_BIT];
        chan_sel = ctrl_word[CH_HI:CH_LO];
        sdo_oe   = rd_active && (ctrl_word[PKG_BIT] == pkg_addr);
    end

    // Unused edge directions, tied off for lint.
    logic unused_edges;
    assign unused_edges = wr_rise ^ rd_fall;

    // R11: after a completed read frame the output is never enabled on its own.
    a_r11_no_oe_without_start: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sdo_oe) && !$past(rd_rise)) |-> $past(rd_active));
endmodule

// File: tb/test_adc_serial_port.sv
module test_adc_serial_port;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, wr_sync_n = 1'b1, rd_sync = 1'b0, sdi = 1'b0, pkg_addr = 1'b0;
    logic [9:0] res_data = '0;
    logic       res_valid = 1'b0;
    logic       sdo, sdo_oe, pwr_down, ext_ref;
    logic [9:0] ctrl_word;
    logic [2:0] chan_sel;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    adc_serial_port i_adc_serial_port (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .wr_sync_n(wr_sync_n), .rd_sync(rd_sync),
        .sdi(sdi), .pkg_addr(pkg_addr), .res_data(res_data), .res_valid(res_valid),
        .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_word(ctrl_word), .pwr_down(pwr_down),
        .ext_ref(ext_ref), .chan_sel(chan_sel));

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One serial clock pulse: rise, then fall.
    task automatic pulse();
        sclk = 1'b1; wait_clks(HALF);
        sclk = 1'b0; wait_clks(HALF);
    endtask

    // Write frame: 'n' pulses, bits MSB first, tail bits for pulses 11..13.
    task automatic wr_frame(input logic [9:0] w, input int n, input logic [2:0] tail);
        wr_sync_n = 1'b0; wait_clks(HALF);
        for (int i = 0; i < n; i++) begin
            sdi = (i < 10) ? w[9-i] : tail[i-10];
            pulse();
        end
        wr_sync_n = 1'b1; wait_clks(HALF);
    endtask

    task automatic strobe(input logic [9:0] v);
        res_data = v; res_valid = 1'b1; wait_clks(1);
        res_valid = 1'b0; wait_clks(1);
    endtask

    // Read frame, checking every bit; optional mid-read result injection.
    task automatic rd_frame(input string req, input logic [9:0] exp, input bit oe_exp,
                            input int inject_at, input logic [9:0] inj);
        rd_sync = 1'b1; wait_clks(HALF);
        check({req, " oe at start"}, sdo_oe, oe_exp);
        if (oe_exp) check({req, " msb at start"}, sdo, exp[9]);
        for (int k = 1; k <= 10; k++) begin
            sclk = 1'b1; wait_clks(HALF);
            if (oe_exp) check($sformatf("%s bit after rise %0d", req, k), sdo, exp[10-k]);
            if (k == inject_at) strobe(inj);
            sclk = 1'b0; wait_clks(HALF);
        end
        sclk = 1'b1; wait_clks(HALF);
        check({req, " R9 oe low at 11th rise"}, sdo_oe, 1'b0);
        sclk = 1'b0; rd_sync = 1'b0; wait_clks(HALF);
    endtask

    task automatic t_reset();
        check("R1 ctrl reset", ctrl_word, 10'h0);
        check("R1 oe reset", sdo_oe, 1'b0);
    endtask

    task automatic t_write_basic();
        logic [9:0] w = 10'b1_1_0_101_0110;
        wr_frame(w, 12, 3'b000);
        check("R3 no commit after 12 pulses", ctrl_word, 10'h0);
        wr_frame(w, 13, 3'b000);
        check("R2 committed word", ctrl_word, w);
        check("R2 pwr_down field", pwr_down, 1'b1);
        check("R2 ext_ref field", ext_ref, 1'b1);
        check("R2 channel field", chan_sel, 3'b101);
        wr_frame(10'b0_1_0_011_1001, 13, 3'b111);
        check("R4 tail bits ignored", ctrl_word, 10'b0_1_0_011_1001);
    endtask

    task automatic t_abort();
        logic [9:0] old = ctrl_word;
        wr_frame(10'b1_0_0_110_0000, 7, 3'b000);
        check("R5 aborted write ignored", ctrl_word, old);
        wr_frame(10'b0_0_0_010_0011, 13, 3'b000);
        check("R5 next frame writes", ctrl_word, 10'b0_0_0_010_0011);
    endtask

    task automatic t_pkg_mismatch();
        wr_frame(10'b1_1_1_111_1111, 13, 3'b000);
        check("R6 mismatched package ignored", ctrl_word, 10'b0_0_0_010_0011);
    endtask

    task automatic t_read();
        for (int i = 0; i < 3; i++) pulse();
        check("R7 no read without sync", sdo_oe, 1'b0);
        strobe(10'h2B5);
        rd_frame("R8 R12 read", 10'h2B5, 1'b1, 0, 10'h0);
        for (int i = 0; i < 2; i++) pulse();
        check("R9 stays off without new sync", sdo_oe, 1'b0);
        rd_frame("R8 second pattern", 10'h2B5, 1'b1, 0, 10'h0);
    endtask

    task automatic t_shadow();
        strobe(10'h14A);
        rd_frame("R10 shadow kept", 10'h14A, 1'b1, 4, 10'h3C3);
        rd_frame("R10 new result next", 10'h3C3, 1'b1, 0, 10'h0);
    endtask

    task automatic t_addr();
        pkg_addr = 1'b1; wait_clks(4);
        rd_frame("R11 other package silent", 10'h3C3, 1'b0, 0, 10'h0);
        wr_frame(10'b0_0_1_001_0000, 13, 3'b000);
        check("R11 matching write", ctrl_word, 10'b0_0_1_001_0000);
        rd_frame("R11 selected read", 10'h3C3, 1'b1, 0, 10'h0);
    endtask

    initial begin
        wait_clks(4);
        t_reset();
        rst_n = 1'b1; wait_clks(4);
        t_reset();
        t_write_basic();
        t_abort();
        t_pkg_mismatch();
        t_read();
        t_shadow();
        t_addr();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule